// File: doc/BRIEF.md
# I2C Configuration Bank with Frame-Aligned Commit

This block is a write-only I2C target that holds twenty-five 8-bit configuration registers for a picture-in-picture display pipeline. A host writes a device address, one subaddress byte, then any number of data bytes. The subaddress advances after each data byte, so one transfer can fill a run of registers.

Some register bits describe the geometry and look of the inset windows. If these bits changed partway through a displayed frame, the picture would tear. These bits are double-buffered. A bus write lands in a staged copy, and the staged copy moves into the active copy on the main-channel vertical sync pulse. A hold bit lets the host block that copy while it stages a whole group of changes. All other bits take effect as soon as their data byte is acknowledged.

The block samples SCL and SDA with the system clock through two-stage synchronisers. It pulls SDA low only in acknowledge slots. It never stretches the clock and never returns read data.

Top module: `pip_cfg_i2c_bank`

## Requirements
- R1: The target pulls SDA low during the ninth clock of the address byte when that byte equals 2CH (7-bit address 16H, write direction). It also pulls SDA low during the ninth clock of every later byte of the same transfer, including bytes aimed above subaddress 18H.
- R2: If the address byte is anything other than 2CH, the target leaves SDA released for that byte and for every other byte until the next START, and no register changes.
- R3: The first byte after the address loads the subaddress pointer. Each data byte writes the register the pointer selects, then the pointer increments, but it never moves past 18H, so it does not wrap to 00H. A data byte while the pointer is above 18H changes nothing.
- R4: The double-buffered bits are: all of registers 00H–07H, 0EH, 11H and 12H; bits 7, 6 and 3 of 0DH; bits 5:0 of 10H; and bits 6:4 and 2:0 of 14H. When the hold bit is 0 in the cycle of a `vsync_i` pulse, all of these bits copy from the staged copy to `cfg_o` in the next cycle. Until then they keep their old active values.
- R5: The hold bit is bit 7 of register 10H, and it takes effect at once. While it is 1, a `vsync_i` pulse leaves every double-buffered bit of `cfg_o` unchanged.
- R6: Every bit outside the R4 set reaches `cfg_o` four clocks after SCL falls at the end of that data byte's acknowledge clock, whatever the hold bit and `vsync_i` are doing.
- R7: Bits 5:0 of register 15H and all bits of 16H, 17H and 18H always read 0 on `cfg_o`, whatever is written to them.
- R8: After reset, every register reads 00H except 14H. Register 14H reads 22H: border width code 2 in bits 6:4 and in bits 2:0, which means 2 lines vertically and 4 pixels horizontally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | I2C clock line (asynchronous) |
| sda_i | input | 1 | I2C data line as seen on the bus (asynchronous) |
| sda_pull_o | output | 1 | 1 drives SDA low (open-drain acknowledge) |
| vsync_i | input | 1 | One-cycle main-channel vertical sync pulse, synchronous to `clk` |
| cfg_o | output | 200 | Active registers; register n occupies bits 8n+7:8n |

## Verification
The bench writes the same register through different paths and checks what each path reveals. Held registers are written with hold clear, then with hold set across a sync pulse, which separates a missing commit from one that ignores the hold. Register 0DH mixes both kinds of bit, and the bench checks it before and after a sync pulse, which shows whether the double-buffer mask sits on the right bit positions. Runs that cross 15H–18H, start at 18H or start above it show whether the reserved bits are masked, whether the pointer saturates and whether out-of-range bytes are dropped. A foreign address byte checks that the target stays silent.

// File: rtl/pip_cfg_pkg.sv
package pip_cfg_pkg;

  localparam int NUM_REGS  = 25;
  localparam int HOLD_REG  = 16;
  localparam int HOLD_BIT  = 7;

  // Bits that pass through the staged copy and commit on vsync.
  function automatic logic [7:0] held_mask(input int idx);
    logic [7:0] m;
    m = 8'h00;
    if (idx <= 7)                    m = 8'hFF;
    else if (idx == 13)              m = 8'hC8;
    else if (idx == 14)              m = 8'hFF;
    else if (idx == 16)              m = 8'h3F;
    else if (idx == 17 || idx == 18) m = 8'hFF;
    else if (idx == 20)              m = 8'h77;
    return m;
  endfunction

  // Bits that can hold a non-zero value at all.
  function automatic logic [7:0] write_mask(input int idx);
    logic [7:0] m;
    m = 8'hFF;
    if (idx == 21)     m = 8'hC0;
    else if (idx > 21) m = 8'h00;
    return m;
  endfunction

  function automatic logic [7:0] reset_value(input int idx);
    return (idx == 20) ? 8'h22 : 8'h00;
  endfunction

endpackage

// File: rtl/pip_cfg_i2c_link.sv
module pip_cfg_i2c_link #(
  parameter logic [7:0] DEV_ADDR = 8'h2C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic       wr_sub_o,
  output logic       wr_data_o,
  output logic [7:0] byte_o
);

  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  logic scl_meta, scl_s, scl_d;
  logic sda_meta, sda_s, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {scl_meta, scl_s, scl_d} <= 3'b111;
      {sda_meta, sda_s, sda_d} <= 3'b111;
    end else begin
      scl_meta <= scl_i;
      scl_s    <= scl_meta;
      scl_d    <= scl_s;
      sda_meta <= sda_i;
      sda_s    <= sda_meta;
      sda_d    <= sda_s;
    end
  end

  logic scl_rise, scl_fall, bus_start, bus_stop;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = scl_d & ~scl_s;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;

  logic       busy_q, sel_q, in_ack_q, pull_q;
  logic [1:0] byte_no_q;   // 0 address, 1 subaddress, 2 data
  logic [3:0] bit_cnt_q;
  logic [7:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      sel_q     <= 1'b0;
      in_ack_q  <= 1'b0;
      pull_q    <= 1'b0;
      byte_no_q <= 2'd0;
      bit_cnt_q <= 4'd0;
      shreg_q   <= 8'h00;
      wr_sub_o  <= 1'b0;
      wr_data_o <= 1'b0;
    end else begin
      wr_sub_o  <= 1'b0;
      wr_data_o <= 1'b0;
      if (bus_start) begin
        busy_q    <= 1'b1;
        sel_q     <= 1'b0;
        in_ack_q  <= 1'b0;
        pull_q    <= 1'b0;
        byte_no_q <= 2'd0;
        bit_cnt_q <= 4'd0;
      end else if (bus_stop) begin
        busy_q   <= 1'b0;
        sel_q    <= 1'b0;
        in_ack_q <= 1'b0;
        pull_q   <= 1'b0;
      end else if (busy_q) begin
        if (scl_rise && !in_ack_q && bit_cnt_q != BITS_PER_BYTE) begin
          shreg_q   <= {shreg_q[6:0], sda_s};
          bit_cnt_q <= bit_cnt_q + 4'd1;
        end
        if (scl_fall) begin
          if (!in_ack_q && bit_cnt_q == BITS_PER_BYTE) begin
            in_ack_q <= 1'b1;
            pull_q   <= (byte_no_q == 2'd0) ? (shreg_q == DEV_ADDR) : sel_q;
          end else if (in_ack_q) begin
            in_ack_q  <= 1'b0;
            pull_q    <= 1'b0;
            bit_cnt_q <= 4'd0;
            if (byte_no_q == 2'd0) begin
              sel_q <= pull_q;
              if (!pull_q) busy_q <= 1'b0;
            end else if (sel_q) begin
              if (byte_no_q == 2'd1) wr_sub_o  <= 1'b1;
              else                   wr_data_o <= 1'b1;
            end
            if (byte_no_q != 2'd2) byte_no_q <= byte_no_q + 2'd1;
          end
        end
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign byte_o     = shreg_q;

  // R1: SDA is only ever pulled inside an acknowledge slot
  p_pull_in_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pull_q |-> in_ack_q);

  // R2: a foreign address byte is never acknowledged
  p_nak_foreign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !bus_start && !bus_stop && scl_fall && !in_ack_q &&
     bit_cnt_q == BITS_PER_BYTE && byte_no_q == 2'd0 && shreg_q != DEV_ADDR)
    |=> !pull_q);

endmodule

// File: rtl/pip_cfg_regfile.sv
module pip_cfg_regfile
  import pip_cfg_pkg::*;
#(
  parameter int N_REGS = NUM_REGS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_sub_i,
  input  logic                wr_data_i,
  input  logic [7:0]          byte_i,
  input  logic                vsync_i,
  output logic [N_REGS*8-1:0] cfg_o
);

  localparam int         LAST     = N_REGS - 1;
  localparam logic [7:0] LAST_PTR = 8'(LAST);

  logic [7:0] ptr_q;
  logic [7:0] stg_q [N_REGS];
  logic [7:0] act_q [N_REGS];
  logic [N_REGS*8-1:0] held_act, held_stg;
  logic       hold, commit;

  assign hold   = act_q[HOLD_REG][HOLD_BIT];
  assign commit = vsync_i & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                ptr_q <= 8'h00;
    else if (wr_sub_i)                         ptr_q <= byte_i;
    else if (wr_data_i && ptr_q < LAST_PTR)    ptr_q <= ptr_q + 8'd1;
  end

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    localparam logic [7:0] HM = held_mask(i);
    localparam logic [7:0] WM = write_mask(i);
    localparam logic [7:0] IM = WM & ~HM;
    logic       hit;
    logic [7:0] act_nxt, stg_nxt;

    assign hit = wr_data_i && (ptr_q == 8'(i));

    always_comb begin
      act_nxt = act_q[i];
      if (commit) act_nxt = (act_q[i] & ~HM) | (stg_q[i] & HM);
      if (hit)    act_nxt = (act_nxt & ~IM) | (byte_i & IM);
      stg_nxt = hit ? (byte_i & WM) : stg_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q[i] <= reset_value(i);
        stg_q[i] <= reset_value(i);
      end else begin
        act_q[i] <= act_nxt;
        stg_q[i] <= stg_nxt;
      end
    end

    assign cfg_o[i*8 +: 8]    = act_q[i];
    assign held_act[i*8 +: 8] = act_q[i] & HM;
    assign held_stg[i*8 +: 8] = stg_q[i] & HM;

    // R7: bits outside the writable set stay zero
    p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q[i] & ~WM) == 8'h00);
  end

  // R4: a commit copies every staged held bit into the active copy
  p_commit_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (held_act == $past(held_stg)));

  // R5: without a commit the held bits of the active copy do not move
  p_held_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(held_act));

  // R3: the pointer saturates at the last register
  p_ptr_saturate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_i && !wr_sub_i && ptr_q == LAST_PTR) |=> (ptr_q == LAST_PTR));

endmodule

// File: rtl/pip_cfg_i2c_bank.sv
module pip_cfg_i2c_bank
  import pip_cfg_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'h2C,
  parameter int         N_REGS   = NUM_REGS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_pull_o,
  input  logic                vsync_i,
  output logic [N_REGS*8-1:0] cfg_o
);

  logic       wr_sub, wr_data;
  logic [7:0] rx_byte;

  pip_cfg_i2c_link #(.DEV_ADDR(DEV_ADDR)) link_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_pull_o (sda_pull_o),
    .wr_sub_o   (wr_sub),
    .wr_data_o  (wr_data),
    .byte_o     (rx_byte)
  );

  pip_cfg_regfile #(.N_REGS(N_REGS)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_sub_i  (wr_sub),
    .wr_data_i (wr_data),
    .byte_i    (rx_byte),
    .vsync_i   (vsync_i),
    .cfg_o     (cfg_o)
  );

  // R6: register strobes come one at a time
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_sub && wr_data));

endmodule

// File: tb/pip_cfg_i2c_bank_tb.sv
module pip_cfg_i2c_bank_tb_top;

  localparam int NR = 25;
  localparam int H  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_drv = 1'b1, vsync = 1'b0;
  logic sda_pull;
  logic [NR*8-1:0] cfg;
  wire  sda_line = sda_drv & ~sda_pull;

  always #10 clk = ~clk;

  pip_cfg_i2c_bank dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .vsync_i(vsync), .cfg_o(cfg)
  );

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  logic [7:0] m_act [NR];
  logic [7:0] m_stg [NR];
  int m_ptr = 0;

  function automatic logic [7:0] m_held(input int r);
    case (r)
      0, 1, 2, 3, 4, 5, 6, 7, 14, 17, 18: return 8'hFF;
      13: return 8'hC8;
      16: return 8'h3F;
      20: return 8'h77;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] m_wr(input int r);
    if (r == 21) return 8'hC0;
    if (r > 21)  return 8'h00;
    return 8'hFF;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_at(input int r);
    return cfg[r*8 +: 8];
  endfunction

  // per-clock comparison against the reference model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_checks++;
      for (int r = 0; r < NR; r++) begin
        if (cfg[r*8 +: 8] !== m_act[r]) begin
          n_fail++;
          $display("FAIL R4/R5/R6 reg %0d actual %h expected %h", r, cfg[r*8 +: 8], m_act[r]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog actual %0d expected <150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_write(input logic [7:0] b);
    if (m_ptr < NR) begin
      m_stg[m_ptr] = b & m_wr(m_ptr);
      m_act[m_ptr] = (m_act[m_ptr] & (m_held(m_ptr) | ~m_wr(m_ptr)))
                   | (b & ~m_held(m_ptr) & m_wr(m_ptr));
      if (m_ptr < NR - 1) m_ptr++;
    end
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wclk(2);
    scl = 1'b1; wclk(H);
    sda_drv = 1'b0; wclk(H);
    scl = 1'b0; wclk(2);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wclk(H);
    scl = 1'b1; wclk(H);
    sda_drv = 1'b1; wclk(H);
  endtask

  // kind: 0 no register effect, 1 subaddress, 2 data
  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input int kind);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wclk(H);
      scl = 1'b1; wclk(H);
      scl = 1'b0; wclk(2);
    end
    sda_drv = 1'b1; wclk(H);
    scl = 1'b1; wclk(H / 2);
    check(exp_ack ? "R1 ack" : "R2 nak", {7'd0, sda_pull}, {7'd0, exp_ack});
    wclk(H - H / 2);
    scl = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    if (kind == 1) m_ptr = int'(b);
    else if (kind == 2) model_write(b);
    @(negedge clk);
  endtask

  task automatic txn(input logic [7:0] addr, input logic [7:0] sub,
                     input logic [7:0] d [6], input int n);
    bit ok;
    ok = (addr == 8'h2C);
    bus_start();
    send_byte(addr, ok, 0);
    send_byte(sub, ok, ok ? 1 : 0);
    for (int i = 0; i < n; i++) send_byte(d[i], ok, ok ? 2 : 0);
    bus_stop();
  endtask

  task automatic pulse_vsync();
    vsync = 1'b1;
    @(posedge clk);
    #1;
    if (m_act[16][7] == 1'b0)
      for (int r = 0; r < NR; r++)
        m_act[r] = (m_act[r] & ~m_held(r)) | (m_stg[r] & m_held(r));
    @(negedge clk);
    vsync = 1'b0;
    wclk(2);
  endtask

  initial begin
    for (int r = 0; r < NR; r++) begin
      m_act[r] = (r == 20) ? 8'h22 : 8'h00;
      m_stg[r] = m_act[r];
    end
    wclk(5);
    rst_n = 1'b1;
    wclk(2);
    check("R8 reset 14H", reg_at(20), 8'h22);
    check("R8 reset 00H", reg_at(0), 8'h00);
    check("R8 reset 10H", reg_at(16), 8'h00);

    // held registers wait for vsync
    txn(8'h2C, 8'h00, '{8'h11, 8'h22, 8'h33, 0, 0, 0}, 3);
    check("R4 before vsync 01H", reg_at(1), 8'h00);
    pulse_vsync();
    check("R4 after vsync 00H", reg_at(0), 8'h11);
    check("R4 after vsync 02H", reg_at(2), 8'h33);

    // immediate registers
    txn(8'h2C, 8'h0A, '{8'h5A, 8'hA5, 0, 0, 0, 0}, 2);
    check("R6 immediate 0AH", reg_at(10), 8'h5A);
    check("R6 immediate 0BH", reg_at(11), 8'hA5);

    // mixed register 0DH
    txn(8'h2C, 8'h0D, '{8'hFF, 0, 0, 0, 0, 0}, 1);
    check("R6 mixed 0DH", reg_at(13), 8'h37);
    pulse_vsync();
    check("R4 mixed 0DH", reg_at(13), 8'hFF);

    // hold set: staged data must not commit
    txn(8'h2C, 8'h10, '{8'h95, 0, 0, 0, 0, 0}, 1);
    check("R5 hold immediate 10H", reg_at(16), 8'h80);
    txn(8'h2C, 8'h00, '{8'h77, 0, 0, 0, 0, 0}, 1);
    pulse_vsync();
    check("R5 held 00H", reg_at(0), 8'h11);
    check("R5 held 10H", reg_at(16), 8'h80);
    txn(8'h2C, 8'h10, '{8'h00, 0, 0, 0, 0, 0}, 1);
    pulse_vsync();
    check("R4 released 00H", reg_at(0), 8'h77);

    // foreign address
    txn(8'h2E, 8'h0A, '{8'hFF, 0, 0, 0, 0, 0}, 1);
    check("R2 no change 0AH", reg_at(10), 8'h5A);

    // border widths: bits 7 and 3 immediate
    txn(8'h2C, 8'h14, '{8'hFF, 0, 0, 0, 0, 0}, 1);
    check("R6 border 14H", reg_at(20), 8'hAA);
    pulse_vsync();
    check("R4 border 14H", reg_at(20), 8'hFF);

    // reserved range and saturation
    txn(8'h2C, 8'h15, '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 0}, 5);
    check("R7 15H", reg_at(21), 8'hC0);
    check("R7 16H", reg_at(22), 8'h00);
    check("R7 18H", reg_at(24), 8'h00);
    txn(8'h2C, 8'h18, '{8'h44, 8'h55, 0, 0, 0, 0}, 2);
    pulse_vsync();
    check("R3 no wrap 00H", reg_at(0), 8'h77);
    check("R3 no wrap 01H", reg_at(1), 8'h22);

    // beyond range
    txn(8'h2C, 8'h1F, '{8'h99, 8'h98, 0, 0, 0, 0}, 2);
    pulse_vsync();
    check("R3 beyond range 00H", reg_at(0), 8'h77);

    // auto-increment across immediate registers
    txn(8'h2C, 8'h08, '{8'h01, 8'h02, 8'h03, 0, 0, 0}, 3);
    check("R3 increment 08H", reg_at(8), 8'h01);
    check("R3 increment 09H", reg_at(9), 8'h02);
    check("R3 increment 0AH", reg_at(10), 8'h03);

    wclk(4);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule